// File: doc/BRIEF.md
# Bus controller reset sequencer

This block is the control core of an external bus controller that must behave differently under its two reset kinds. A power-on reset wipes everything at once: bus strobes fall in the middle of whatever cycle is running, the configuration returns to its reset values and, in slave arbitration mode, the pin drivers are switched off together with the strobes. A manual reset is gentler. The configuration is kept, the beat on the bus is allowed to finish, a four-beat burst is cut at the next longword boundary, the refresh interval counter is frozen and the master-side arbiter keeps serving external bus release requests.

Requests arrive as a single-cycle `reqValid` pulse with a burst flag. A single access becomes one longword beat and a burst becomes four, one clock each. A refresh counter counts clocks against a programmable compare value and raises a sticky refresh request that a one-cycle acknowledge clears. An external requester can take the bus. The block then stops starting cycles, turns its drivers off and reports the grant. During a power-on reset the grant output is forced inactive, but the bus stays released for as long as the requester holds its line.

Top module: `busResetSeq`

## Requirements
- R1: While `porRstIn` is high, `busStrobe`, `burstStrobe`, `refReq` and `relGrant` are 0. They fall at once when the pin rises, even in the middle of a burst. Refresh enable is cleared and the compare value returns to `CMP_RST`, so no refresh request appears after release until software writes the configuration. A power-on reset overrides a manual reset.
- R2: When `slaveMode` is 1, `drvEn` falls to 0 at the same moment that the strobes fall on power-on reset.
- R3: A manual reset leaves refresh enable and the compare value unchanged. After it, consecutive refresh requests are again compare+1 clocks apart.
- R4: A single access gives one beat (`busStrobe`=1, `beatNum`=0, `burstStrobe`=0) in the cycle after the clock edge that samples `reqValid`. A burst gives four consecutive beats with `beatNum` 0, 1, 2, 3 and `burstStrobe`=1.
- R5: `manRstIn` passes through a two-stage synchroniser. When a synchronised manual reset is seen at a beat boundary, the running burst ends after that beat. If `manRstIn` rises in the same cycle as a burst request, exactly beats 0 and 1 are issued.
- R6: No request is accepted while the synchronised manual reset is high. After the reset is released, requests are accepted normally.
- R7: With refresh enabled, the counter advances once per clock. It clears on a match with the compare value and sets `refReq`. The first request comes compare+2 clocks after the configuration write. Acknowledged requests rise compare+1 clocks apart. `refReq` stays high until `refAck` is sampled high.
- R8: While the synchronised manual reset is high, the refresh counter holds its value, so the interval grows by the reset length. `refReq` is held low during that time. A request that was already pending shows again after the reset.
- R9: When the sequencer is idle, `extRelReq` gives `relGrant`=1 and `drvEn`=0 from the next clock. This also holds during a manual reset. A running cycle completes before the grant. No request is accepted while the bus is released or `extRelReq` is high. One clock after `extRelReq` falls, `relGrant` returns to 0 and `drvEn` returns to 1.
- R10: A power-on reset while the bus is released forces `relGrant` to 0 at once. `drvEn` stays 0 while `extRelReq` stays high, and `relGrant` returns once the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstIn | input | 1 | Power-on reset, active high, asynchronous assertion |
| manRstIn | input | 1 | Manual reset, active high, synchronised internally |
| slaveMode | input | 1 | 1 = slave arbitration mode |
| cfgWe | input | 1 | Writes refresh enable and compare value |
| cfgRefEn | input | 1 | Refresh enable value to write |
| cfgCmp | input | CNT_W | Refresh compare value to write |
| reqValid | input | 1 | Access request pulse |
| reqBurst | input | 1 | 1 = four-beat burst, 0 = single beat |
| refAck | input | 1 | Clears the pending refresh request |
| extRelReq | input | 1 | External bus release request |
| busStrobe | output | 1 | High for each longword beat on the bus |
| burstStrobe | output | 1 | High for beats that belong to a burst |
| beatNum | output | BEAT_W | Index of the current beat |
| drvEn | output | 1 | Output-enable for the bus drivers |
| refReq | output | 1 | Refresh request |
| relGrant | output | 1 | Bus released to the external requester |

## Verification
Beats appear in the cycle after the edge that takes the request, one per clock. A manual reset acts at the beat boundary two clocks after the pin rises, because of its synchroniser. The grant and its withdrawal follow `extRelReq` by one clock, and the refresh interval is compare+1 clocks, plus one clock per frozen cycle. The power-on effects on strobes, grant and drivers are checked a nanosecond after the pin rises, in the middle of the clock's low phase. All other results are sampled on falling edges, a counted number of edges after the stimulus. Beats are compared through a queue of expected beat codes filled before each request. Any beat that arrives with no code waiting, with the wrong code, or that is missing when the queue is checked is a failure.

// File: rtl/busrst_pkg.sv
package busrst_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_BEAT} seqState_t;

  typedef struct packed {
    logic start;
    logic burst;
    logic advance;
    logic freeze;
  } seqStrobe_t;
endpackage

// File: rtl/busrst_sync.sv
module busrst_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/busrst_ctrl.sv
module busrst_ctrl
  import busrst_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqBurst,
  input  logic              manRst,
  input  logic              extRelReq,
  input  logic [BEAT_W-1:0] beatCnt,
  input  logic              burstFlag,
  output seqStrobe_t        strobe,
  output logic              cycleOn,
  output logic              relHeld
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seqState_t state;
  logic isIdle, startCycle, endCycle;

  assign isIdle     = (state == SEQ_IDLE);
  assign startCycle = isIdle && reqValid && !manRst && !extRelReq && !relHeld;
  assign endCycle   = (state == SEQ_BEAT) &&
                      (!burstFlag || (beatCnt == LAST_BEAT) || manRst);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= SEQ_IDLE;
    else if (startCycle) state <= SEQ_BEAT;
    else if (endCycle) state <= SEQ_IDLE;
  end

  // Release flag keeps following the requester through a power-on reset.
  always_ff @(posedge clk) begin
    relHeld <= extRelReq && (relHeld || isIdle);
  end

  always_comb begin
    strobe.start   = startCycle;
    strobe.burst   = reqBurst;
    strobe.advance = (state == SEQ_BEAT) && !endCycle;
    strobe.freeze  = manRst;
  end

  assign cycleOn = (state == SEQ_BEAT);

  p_beat_step_r4: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_BEAT && $past(state == SEQ_BEAT)) |-> beatCnt == $past(beatCnt) + 1'b1);

  p_cancel_r5: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_BEAT && manRst) |=> state == SEQ_IDLE);

  p_no_start_r6: assert property (@(posedge clk) disable iff (rst)
    (isIdle && manRst) |=> state == SEQ_IDLE);

  p_rel_block_r9: assert property (@(posedge clk) disable iff (rst)
    (isIdle && (relHeld || extRelReq)) |=> state == SEQ_IDLE);
endmodule

// File: rtl/busrst_dpath.sv
module busrst_dpath
  import busrst_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 10,
  parameter int unsigned CMP_RST = 500,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  input  logic              cfgWe,
  input  logic              cfgRefEn,
  input  logic [CNT_W-1:0]  cfgCmp,
  input  logic              refAck,
  output logic [BEAT_W-1:0] beatCnt,
  output logic              burstFlag,
  output logic              refReq
);
  logic             refEnReg;
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] refCnt;
  logic             refPend;
  logic             cntEn, cntMatch;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      refEnReg <= 1'b0;
      cmpReg   <= CNT_W'(CMP_RST);
    end else if (cfgWe) begin
      refEnReg <= cfgRefEn;
      cmpReg   <= cfgCmp;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      beatCnt   <= '0;
      burstFlag <= 1'b0;
    end else if (strobe.start) begin
      beatCnt   <= '0;
      burstFlag <= strobe.burst;
    end else if (strobe.advance) begin
      beatCnt   <= beatCnt + 1'b1;
    end
  end

  assign cntEn    = refEnReg && !strobe.freeze;
  assign cntMatch = (refCnt == cmpReg);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      refCnt  <= '0;
      refPend <= 1'b0;
    end else begin
      if (cntEn) refCnt <= cntMatch ? '0 : refCnt + 1'b1;
      refPend <= (cntEn && cntMatch) || (refPend && !refAck);
    end
  end

  assign refReq = refPend && !strobe.freeze;

  p_keep_cfg_r3: assert property (@(posedge clk) disable iff (rst)
    !cfgWe |=> ($stable(cmpReg) && $stable(refEnReg)));

  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (refPend && !refAck) |=> refPend);

  p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.freeze |=> $stable(refCnt));
endmodule

// File: rtl/busResetSeq.sv
module busResetSeq
  import busrst_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int CNT_W = 10,
  parameter int unsigned CMP_RST = 500,
  parameter int SYNC_STAGES = 2,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              porRstIn,
  input  logic              manRstIn,
  input  logic              slaveMode,
  input  logic              cfgWe,
  input  logic              cfgRefEn,
  input  logic [CNT_W-1:0]  cfgCmp,
  input  logic              reqValid,
  input  logic              reqBurst,
  input  logic              refAck,
  input  logic              extRelReq,
  output logic              busStrobe,
  output logic              burstStrobe,
  output logic [BEAT_W-1:0] beatNum,
  output logic              drvEn,
  output logic              refReq,
  output logic              relGrant
);
  logic porActive, manRst, cycleOn, relHeld, burstFlag;
  logic [BEAT_W-1:0] beatCnt;
  seqStrobe_t strobe;

  busrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) porSync_i (
    .clk(clk), .clr(porRstIn), .d(1'b0), .q(porActive));

  busrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) manSync_i (
    .clk(clk), .clr(porActive), .d(manRstIn), .q(manRst));

  busrst_ctrl #(.BEATS(BEATS)) ctrl_i (
    .clk(clk), .rst(porActive), .reqValid(reqValid), .reqBurst(reqBurst),
    .manRst(manRst), .extRelReq(extRelReq), .beatCnt(beatCnt),
    .burstFlag(burstFlag), .strobe(strobe), .cycleOn(cycleOn), .relHeld(relHeld));

  busrst_dpath #(.BEATS(BEATS), .CNT_W(CNT_W), .CMP_RST(CMP_RST)) dpath_i (
    .clk(clk), .rst(porActive), .strobe(strobe), .cfgWe(cfgWe),
    .cfgRefEn(cfgRefEn), .cfgCmp(cfgCmp), .refAck(refAck),
    .beatCnt(beatCnt), .burstFlag(burstFlag), .refReq(refReq));

  assign busStrobe   = cycleOn;
  assign burstStrobe = cycleOn && burstFlag;
  assign beatNum     = beatCnt;
  assign drvEn       = !relHeld && !(porActive && slaveMode);
  assign relGrant    = relHeld && !porActive;

  always @(negedge clk) begin
    if (porActive) begin
      p_por_quiet_r1: assert (!busStrobe && !burstStrobe && !refReq);
      p_grant_off_r10: assert (!relGrant);
      if (slaveMode) begin
        p_drv_off_r2: assert (!drvEn);
      end
    end
  end
endmodule

// File: tb/busResetSeq_tb_top.sv
module busResetSeq_tb_top;
  localparam int CNT_W = 10;
  localparam int CMP   = 20;

  logic clk = 1'b0;
  logic porRstIn, manRstIn, slaveMode, cfgWe, cfgRefEn;
  logic [CNT_W-1:0] cfgCmp;
  logic reqValid, reqBurst, refAck, extRelReq;
  logic busStrobe, burstStrobe, drvEn, refReq, relGrant;
  logic [1:0] beatNum;

  int checks = 0;
  int failures = 0;
  int expQ[$];
  string curReq = "R4";

  always #5 clk = ~clk;

  busResetSeq #(.BEATS(4), .CNT_W(CNT_W), .CMP_RST(500)) dut_i (
    .clk(clk), .porRstIn(porRstIn), .manRstIn(manRstIn), .slaveMode(slaveMode),
    .cfgWe(cfgWe), .cfgRefEn(cfgRefEn), .cfgCmp(cfgCmp), .reqValid(reqValid),
    .reqBurst(reqBurst), .refAck(refAck), .extRelReq(extRelReq),
    .busStrobe(busStrobe), .burstStrobe(burstStrobe), .beatNum(beatNum),
    .drvEn(drvEn), .refReq(refReq), .relGrant(relGrant));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: every beat must match the next queued code (beatNum + 4 for burst).
  always @(negedge clk) begin
    if (busStrobe === 1'b1) begin
      int code;
      code = int'(beatNum) + (burstStrobe ? 4 : 0);
      if (expQ.size() == 0) chk({curReq, " unexpected beat"}, code, -1);
      else chk({curReq, " beat code"}, code, expQ.pop_front());
    end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseReq(input logic burst);
    reqValid = 1'b1;
    reqBurst = burst;
    @(negedge clk);
    reqValid = 1'b0;
    reqBurst = 1'b0;
  endtask

  task automatic pushBeats(input bit burst, input int n);
    for (int i = 0; i < n; i++) expQ.push_back(i + (burst ? 4 : 0));
  endtask

  // Called on the falling edge where refReq is seen high; returns edges to next rise.
  task automatic measureGap(input int manLen, output int g);
    g = 0;
    @(negedge clk); g = 1; refAck = 1'b1;
    @(negedge clk); g = 2; refAck = 1'b0;
    if (manLen > 0) manRstIn = 1'b1;
    while (!refReq && g < 500) begin
      @(negedge clk);
      g++;
      if (g == 2 + manLen) manRstIn = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n, g, seen;
    porRstIn = 1'b0; manRstIn = 0; slaveMode = 0; cfgWe = 0; cfgRefEn = 0;
    cfgCmp = '0; reqValid = 0; reqBurst = 0; refAck = 0; extRelReq = 0;
    #1 porRstIn = 1'b1;
    waitN(5);
    porRstIn = 1'b0;
    waitN(4);
    chk("R1 reset busStrobe", busStrobe, 0);
    chk("R1 reset refReq", refReq, 0);
    chk("R1 reset relGrant", relGrant, 0);
    chk("R1 reset drvEn", drvEn, 1);

    // R4 single and burst
    curReq = "R4";
    pushBeats(0, 1); pulseReq(1'b0); waitN(5);
    chk("R4 single drained", expQ.size(), 0);
    pushBeats(1, 4); pulseReq(1'b1); waitN(7);
    chk("R4 burst drained", expQ.size(), 0);

    // R7 refresh timing
    cfgWe = 1'b1; cfgRefEn = 1'b1; cfgCmp = CNT_W'(CMP);
    @(negedge clk); cfgWe = 1'b0; n = 1;
    while (!refReq && n < 500) begin @(negedge clk); n++; end
    chk("R7 first refresh delay", n, CMP + 2);
    waitN(5);
    chk("R7 refReq sticky", refReq, 1);
    measureGap(0, g);
    chk("R7 gap after late ack", g, CMP + 1 - 5);
    measureGap(0, g);
    chk("R7 refresh interval", g, CMP + 1);
    measureGap(10, g);
    chk("R8 interval with freeze", g, CMP + 1 + 10);
    manRstIn = 1'b1; waitN(3);
    chk("R8 refReq masked", refReq, 0);
    manRstIn = 1'b0; waitN(3);
    chk("R8 pending shows again", refReq, 1);
    measureGap(0, g);
    measureGap(0, g);
    chk("R3 interval kept after manual reset", g, CMP + 1);

    // R5 burst cut by manual reset, R6 requests ignored during it
    curReq = "R5";
    pushBeats(1, 2);
    manRstIn = 1'b1;
    pulseReq(1'b1);
    waitN(2);
    curReq = "R6";
    pulseReq(1'b0);
    waitN(3);
    manRstIn = 1'b0;
    waitN(4);
    chk("R5 burst cut at two beats", expQ.size(), 0);
    pushBeats(0, 1); pulseReq(1'b0); waitN(3);
    chk("R6 request served after release", expQ.size(), 0);

    // R9 release during manual reset, blocking, and wait for running burst
    curReq = "R9";
    manRstIn = 1'b1; waitN(3);
    extRelReq = 1'b1; @(negedge clk);
    chk("R9 grant during manual reset", relGrant, 1);
    chk("R9 drivers off while released", drvEn, 0);
    pulseReq(1'b0);
    manRstIn = 1'b0; waitN(4);
    pulseReq(1'b1); waitN(3);
    extRelReq = 1'b0; @(negedge clk);
    chk("R9 grant dropped", relGrant, 0);
    chk("R9 drivers back", drvEn, 1);
    waitN(3);
    chk("R9 no beats while released", expQ.size(), 0);
    pushBeats(1, 4); pulseReq(1'b1);
    extRelReq = 1'b1;
    waitN(3);
    chk("R9 grant waits for burst", relGrant, 0);
    @(negedge clk);
    chk("R9 grant waits one idle edge", relGrant, 0);
    @(negedge clk);
    chk("R9 grant after burst", relGrant, 1);
    chk("R9 burst completed", expQ.size(), 0);
    extRelReq = 1'b0; waitN(3);

    // R1 and R2: power-on reset in the middle of a burst, slave mode
    curReq = "R1";
    slaveMode = 1'b1; waitN(2);
    pushBeats(1, 2); pulseReq(1'b1);
    @(negedge clk);
    #2 porRstIn = 1'b1;
    #1;
    chk("R1 strobe falls at once", busStrobe, 0);
    chk("R1 burst strobe falls at once", burstStrobe, 0);
    chk("R2 drivers off with strobes", drvEn, 0);
    waitN(4);
    porRstIn = 1'b0; slaveMode = 1'b0;
    waitN(4);
    chk("R1 burst not resumed", expQ.size(), 0);
    chk("R1 drivers on after reset", drvEn, 1);
    seen = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (refReq) seen = 1; end
    chk("R1 refresh enable cleared", seen, 0);

    // R10 power-on reset while released
    extRelReq = 1'b1; waitN(2);
    chk("R10 grant before reset", relGrant, 1);
    #2 porRstIn = 1'b1;
    #1;
    chk("R10 grant off at once", relGrant, 0);
    chk("R10 drivers stay off", drvEn, 0);
    waitN(4);
    chk("R10 grant off during reset", relGrant, 0);
    chk("R10 still released", drvEn, 0);
    porRstIn = 1'b0; waitN(4);
    chk("R10 grant back after reset", relGrant, 1);
    extRelReq = 1'b0; waitN(2);
    chk("R10 released bus returned", drvEn, 1);
    chk("R10 grant cleared", relGrant, 0);
    report();
  end
endmodule